// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a synchronous host and an asynchronous fast-page-mode DRAM array. It accepts read and write requests on a valid/ready port and turns each one into the row strobe, column strobe, write strobe, output-enable and multiplexed address sequence that the array needs. Every phase of that sequence lasts a whole number of clock cycles. Each count comes from a nanosecond minimum divided by the clock period and rounded up, so one parameter set serves any clock rate.

After an access the row stays open. A following request to the same row is served as a column-only (page) cycle. A request to another row, a pending refresh, an idle timeout, or a row-strobe low time that nears its ceiling closes the row. The row strobe then rises only once its minimum low time has passed, and a full precharge follows before anything else starts. Refresh uses the column-before-row method. It is granted only between accesses and is acknowledged with a single-cycle pulse.

Writes always use the early-write form. The write strobe and the write data are set up before the column strobe falls, and the output enable stays high. Read data is captured at the edge that ends the column-strobe low phase. That edge comes no sooner than the column access time.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is asserted, the row, column, write and output-enable strobes are all high, the data drive enable is low and no response or acknowledge is given. After reset, `req_ready_o` stays low until a full precharge time has elapsed.
- R2: The row address is stable at least T_ASR_NS before the row strobe falls, and at least T_RAH_NS after it falls, before the column address replaces it.
- R3: The row strobe is low for at least T_RAS_NS and high for at least T_RP_NS between any two low phases.
- R4: The column strobe falls at least T_RCD_NS after the row strobe falls. It is low for at least T_CAS_NS and high for at least T_CP_NS. Two falls within one row-strobe low phase are at least T_PC_NS apart. The address is stable while the column strobe is low.
- R5: A read is answered by `rsp_valid_o` high for exactly one cycle, with the data the array drove at least T_CAC_NS after the column strobe fell.
- R6: A write lowers the write strobe at least one cycle before the column strobe falls, keeps the output enable high, and drives the data for at least T_DH_NS after the column strobe falls.
- R7: Consecutive requests to the open row are served without a new row-strobe fall.
- R8: A request to a row other than the open one closes that row, precharges, and opens the new row, giving one extra row-strobe fall.
- R9: A refresh request lowers the column strobe at least T_CSR_NS before the row strobe falls while no access is in flight. The block pulses `ref_ack_o` for one cycle when the row strobe rises at the end of the refresh.
- R10: The row strobe is never held low for T_RASMAX_NS or longer. A long run of page hits is split by a forced close.
- R11: After IDLE_CYC cycles in which the open row receives no request, the row is closed. It stays open for shorter gaps.
- R12: The column address is stable for at least T_RAL_NS before the row strobe rises at the end of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Request accepted on this edge when valid is high |
| req_addr_i | input | ROW_W+COL_W | Request address, row in the upper bits, column in the lower bits |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | DW | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle |
| rsp_rdata_o | output | DW | Read data |
| ref_req_i | input | 1 | Refresh request, held until acknowledged |
| ref_ack_o | output | 1 | Refresh done, one-cycle pulse |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write strobe, active low |
| dram_oe_no | output | 1 | Output enable, active low |
| dram_addr_o | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq_o | output | DW | Data towards the array |
| dram_dq_oe_o | output | 1 | Drive enable for dram_dq_o |
| dram_dq_i | input | DW | Data from the array |

## Verification
A wrong phase count or a wrong state transition shows on the strobe pins at the first edge that ends the phase too early. The bench's behavioural array measures every edge spacing in nanoseconds and charges each violation to its requirement. A read sampled before the access time returns the bitwise complement of the stored word, so a premature capture turns into a data mismatch on the very response. A faulty open-row decision shows up in the count of row-strobe falls across a page run or a row change. A broken close condition leaves the row strobe low past the idle gap or past the ceiling, and the bench sees this within a few tens of cycles.

// File: rtl/fpm_pkg.sv
`timescale 1ns/1ps
package fpm_pkg;

  typedef enum logic [3:0] {
    ST_PRE, ST_IDLE, ST_ROW, ST_RAH, ST_RCD, ST_CAS,
    ST_CP, ST_OPEN, ST_CLOSE, ST_REF_CSR, ST_REF_RAS
  } fpm_state_e;

  // whole cycles covering ns, never below one
  function automatic int ns2cyc(int ns, int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fpm_ras_monitor.sv
`timescale 1ns/1ps
module fpm_ras_monitor #(
  parameter int CW     = 16,
  parameter int MIN_C  = 6,
  parameter int NEAR_C = 100,
  parameter int MAX_C  = 120
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ras_n_i,
  output logic [CW-1:0] cnt_o,
  output logic          min_ok_o,
  output logic          near_max_o
);
  localparam logic [CW-1:0] MinM1  = CW'(MIN_C - 1);
  localparam logic [CW-1:0] NearM1 = CW'(NEAR_C - 1);
  localparam logic [CW-1:0] MaxV   = CW'(MAX_C);
  localparam logic [CW-1:0] SatV   = {CW{1'b1}};

  logic [CW-1:0] cnt_q;

  // cnt_q + 1 = cycles since the strobe fell
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (ras_n_i)      cnt_q <= '0;
    else if (cnt_q != SatV) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o      = cnt_q;
  assign min_ok_o   = !ras_n_i && (cnt_q >= MinM1);
  assign near_max_o = !ras_n_i && (cnt_q >= NearM1);

  assert_ras_max_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_i |-> cnt_q < MaxV);

  assert_ras_min_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_i) |-> $past(cnt_q) >= MinM1);

endmodule

// File: rtl/fpm_row_tracker.sv
`timescale 1ns/1ps
module fpm_row_tracker #(
  parameter int ROW_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [ROW_W-1:0] req_row_i,
  output logic             hit_o
);
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     row_q <= '0;
    else if (load_i) row_q <= row_i;
  end

  assign hit_o = (req_row_i == row_q);

endmodule

// File: rtl/fpm_dram_ctrl.sv
`timescale 1ns/1ps
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int CLK_NS      = 10,
  parameter int ROW_W       = 10,
  parameter int COL_W       = 10,
  parameter int DW          = 72,
  parameter int T_RAS_NS    = 60,
  parameter int T_RP_NS     = 40,
  parameter int T_ASR_NS    = 5,
  parameter int T_RAH_NS    = 8,
  parameter int T_RCD_NS    = 18,
  parameter int T_CAS_NS    = 15,
  parameter int T_CP_NS     = 10,
  parameter int T_PC_NS     = 40,
  parameter int T_CAC_NS    = 20,
  parameter int T_DH_NS     = 15,
  parameter int T_CSR_NS    = 12,
  parameter int T_RAL_NS    = 35,
  parameter int T_RASMAX_NS = 200000,
  parameter int IDLE_CYC    = 64
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic [ROW_W+COL_W-1:0] req_addr_i,
  input  logic                   req_write_i,
  input  logic [DW-1:0]          req_wdata_i,
  output logic                   rsp_valid_o,
  output logic [DW-1:0]          rsp_rdata_o,
  input  logic                   ref_req_i,
  output logic                   ref_ack_o,
  output logic                   dram_ras_no,
  output logic                   dram_cas_no,
  output logic                   dram_we_no,
  output logic                   dram_oe_no,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr_o,
  output logic [DW-1:0]          dram_dq_o,
  output logic                   dram_dq_oe_o,
  input  logic [DW-1:0]          dram_dq_i
);
  localparam int AW     = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int RA_W   = ROW_W + COL_W;
  localparam int TRP_C  = ns2cyc(T_RP_NS, CLK_NS);
  localparam int TRAS_C = ns2cyc(T_RAS_NS, CLK_NS);
  localparam int ASR_C  = ns2cyc(T_ASR_NS, CLK_NS);
  localparam int RAH_C  = ns2cyc(T_RAH_NS, CLK_NS);
  localparam int RCD_C  = ns2cyc(T_RCD_NS, CLK_NS);
  localparam int COL_C  = imax(1, RCD_C - RAH_C);
  localparam int CL_C   = ns2cyc(imax(T_CAS_NS, imax(T_CAC_NS, T_DH_NS)), CLK_NS);
  localparam int PC_C   = ns2cyc(imax(T_PC_NS, T_RAL_NS), CLK_NS);
  localparam int CP_C   = imax(ns2cyc(T_CP_NS, CLK_NS), PC_C - CL_C - 1);
  localparam int CSR_C  = ns2cyc(T_CSR_NS, CLK_NS);
  localparam int MAX_C  = T_RASMAX_NS / CLK_NS;
  localparam int BUDGET = CL_C + CP_C + 4;
  localparam int NEAR_C = imax(TRAS_C, MAX_C - BUDGET);
  localparam int CW     = $clog2(MAX_C + 2);
  localparam int WW     = 8;
  localparam int IW     = $clog2(IDLE_CYC + 1);
  localparam logic [IW-1:0] IdleLim = IW'(IDLE_CYC);

  fpm_state_e       state_q;
  logic [WW-1:0]    wait_q;
  logic [IW-1:0]    idle_q;
  logic [COL_W-1:0] col_q;
  logic             wr_q;
  logic [DW-1:0]    wdata_q;
  logic [CW-1:0]    ras_cnt;
  logic             ras_min_ok, ras_near_max, row_hit;
  logic             close_now, accept, tmr_done;

  wire [ROW_W-1:0] req_row = req_addr_i[RA_W-1:COL_W];
  wire [COL_W-1:0] req_col = req_addr_i[COL_W-1:0];

  fpm_ras_monitor #(.CW(CW), .MIN_C(TRAS_C), .NEAR_C(NEAR_C), .MAX_C(MAX_C)) u_ras_mon (
    .clk_i(clk_i), .rst_ni(rst_ni), .ras_n_i(dram_ras_no),
    .cnt_o(ras_cnt), .min_ok_o(ras_min_ok), .near_max_o(ras_near_max));

  fpm_row_tracker #(.ROW_W(ROW_W)) u_row_trk (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(accept && (state_q == ST_IDLE)), .row_i(req_row),
    .req_row_i(req_row), .hit_o(row_hit));

  assign tmr_done  = (wait_q == '0);
  assign close_now = ref_req_i || (idle_q >= IdleLim) || ras_near_max
                   || (req_valid_i && !row_hit);
  assign req_ready_o = ((state_q == ST_IDLE) && !ref_req_i)
                    || ((state_q == ST_OPEN) && !close_now);
  assign accept = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_PRE;
      wait_q       <= WW'(TRP_C - 1);
      idle_q       <= '0;
      col_q        <= '0;
      wr_q         <= 1'b0;
      wdata_q      <= '0;
      dram_ras_no  <= 1'b1;
      dram_cas_no  <= 1'b1;
      dram_we_no   <= 1'b1;
      dram_oe_no   <= 1'b1;
      dram_dq_oe_o <= 1'b0;
      dram_addr_o  <= '0;
      rsp_valid_o  <= 1'b0;
      rsp_rdata_o  <= '0;
      ref_ack_o    <= 1'b0;
    end else begin
      rsp_valid_o <= 1'b0;
      ref_ack_o   <= 1'b0;
      if (!tmr_done) wait_q <= wait_q - 1'b1;
      unique case (state_q)
        ST_PRE: if (tmr_done) state_q <= ST_IDLE;
        ST_IDLE: begin
          if (ref_req_i) begin
            dram_cas_no <= 1'b0;
            wait_q      <= WW'(CSR_C - 1);
            state_q     <= ST_REF_CSR;
          end else if (accept) begin
            dram_addr_o <= AW'(req_row);
            col_q       <= req_col;
            wr_q        <= req_write_i;
            wdata_q     <= req_wdata_i;
            wait_q      <= WW'(ASR_C - 1);
            state_q     <= ST_ROW;
          end
        end
        ST_ROW: if (tmr_done) begin
          dram_ras_no <= 1'b0;
          wait_q      <= WW'(RAH_C - 1);
          state_q     <= ST_RAH;
        end
        ST_RAH: if (tmr_done) begin
          dram_addr_o  <= AW'(col_q);
          dram_we_no   <= !wr_q;
          dram_oe_no   <= wr_q;
          dram_dq_oe_o <= wr_q;
          dram_dq_o    <= wdata_q;
          wait_q       <= WW'(COL_C - 1);
          state_q      <= ST_RCD;
        end
        ST_RCD: if (tmr_done) begin
          dram_cas_no <= 1'b0;
          wait_q      <= WW'(CL_C - 1);
          state_q     <= ST_CAS;
        end
        ST_CAS: if (tmr_done) begin
          dram_cas_no  <= 1'b1;
          dram_we_no   <= 1'b1;
          dram_oe_no   <= 1'b1;
          dram_dq_oe_o <= 1'b0;
          if (!wr_q) begin
            rsp_rdata_o <= dram_dq_i;
            rsp_valid_o <= 1'b1;
          end
          wait_q  <= WW'(CP_C - 1);
          state_q <= ST_CP;
        end
        ST_CP: if (tmr_done) begin
          idle_q  <= '0;
          state_q <= ST_OPEN;
        end
        ST_OPEN: begin
          if (idle_q != IdleLim) idle_q <= idle_q + 1'b1;
          if (close_now) begin
            state_q <= ST_CLOSE;
          end else if (accept) begin
            // page hit: column only, one cycle of setup before the strobe
            dram_addr_o  <= AW'(req_col);
            wr_q         <= req_write_i;
            dram_we_no   <= !req_write_i;
            dram_oe_no   <= req_write_i;
            dram_dq_oe_o <= req_write_i;
            dram_dq_o    <= req_wdata_i;
            idle_q       <= '0;
            wait_q       <= '0;
            state_q      <= ST_RCD;
          end
        end
        ST_CLOSE: if (ras_min_ok) begin
          dram_ras_no <= 1'b1;
          wait_q      <= WW'(TRP_C - 1);
          state_q     <= ST_PRE;
        end
        ST_REF_CSR: if (tmr_done) begin
          dram_ras_no <= 1'b0;
          state_q     <= ST_REF_RAS;
        end
        ST_REF_RAS: if (ras_min_ok) begin
          dram_ras_no <= 1'b1;
          dram_cas_no <= 1'b1;
          ref_ack_o   <= 1'b1;
          wait_q      <= WW'(TRP_C - 1);
          state_q     <= ST_PRE;
        end
        default: state_q <= ST_PRE;
      endcase
    end
  end

  assert_early_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dram_cas_no) && !dram_ras_no) |-> $stable(dram_we_no));

  assert_drive_on_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dram_dq_oe_o |-> (!dram_we_no && dram_oe_no));

  assert_rsp_after_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(!dram_cas_no && !dram_oe_no && dram_we_no));

  assert_addr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dram_cas_no && $past(!dram_cas_no)) |-> $stable(dram_addr_o));

  assert_ref_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_ack_o |-> (dram_ras_no && dram_cas_no && !rsp_valid_o));

  assert_single_rsp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

endmodule

// File: tb/fpm_dram_ctrl_tb.sv
`timescale 1ns/1ps
module fpm_dram_ctrl_tb;
  localparam int  CLK_NS = 8;
  localparam int  ROW_W  = 4;
  localparam int  COL_W  = 4;
  localparam int  DW     = 16;
  localparam int  RASMAX = 800;
  localparam int  IDLE   = 20;
  localparam real TP     = 40.0, TRAS = 60.0, TASR = 5.0, TRAH = 8.0;
  localparam real TRCD   = 18.0, TCAS = 15.0, TCPR = 10.0, TPC = 40.0;
  localparam real TDH    = 15.0, TCSR = 12.0, TRAL = 35.0, TWCS = 2.0;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_write_i = 1'b0, ref_req_i = 1'b0;
  logic [ROW_W+COL_W-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic req_ready_o, rsp_valid_o, ref_ack_o;
  logic [DW-1:0] rsp_rdata_o;
  logic dram_ras_no, dram_cas_no, dram_we_no, dram_oe_no, dram_dq_oe_o;
  logic [3:0] dram_addr_o;
  logic [DW-1:0] dram_dq_o, dram_dq_i;

  always #4 clk = ~clk;

  fpm_dram_ctrl #(.CLK_NS(CLK_NS), .ROW_W(ROW_W), .COL_W(COL_W), .DW(DW),
                  .T_RASMAX_NS(RASMAX), .IDLE_CYC(IDLE)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_write_i(req_write_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o), .ref_req_i(ref_req_i),
    .ref_ack_o(ref_ack_o), .dram_ras_no(dram_ras_no), .dram_cas_no(dram_cas_no),
    .dram_we_no(dram_we_no), .dram_oe_no(dram_oe_no), .dram_addr_o(dram_addr_o),
    .dram_dq_o(dram_dq_o), .dram_dq_oe_o(dram_dq_oe_o), .dram_dq_i(dram_dq_i));

  // ---- behavioural array with timing checks ----
  logic [DW-1:0] mem [0:255];
  logic [ROW_W-1:0] row_l = '0;
  logic rd_ok = 1'b0, cbr = 1'b0;
  logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1, p_dqoe = 1'b0;
  logic [3:0] p_addr = '0;
  logic [DW-1:0] p_dq = '0;
  real t_rf = -1000.0, t_rr = -1000.0, t_cf = -1000.0, t_cr = -1000.0;
  real t_ac = -1000.0, t_wf = -1000.0, now, max_low = 0.0;
  int v_r2 = 0, v_r3 = 0, v_r4 = 0, v_r6 = 0, v_r9 = 0, v_r10 = 0, v_r12 = 0;
  int ras_falls = 0, ref_seen = 0;

  initial for (int i = 0; i < 256; i++) mem[i] = '0;

  always @(negedge dram_cas_no) begin
    rd_ok = 1'b0;
    #20;
    rd_ok = !dram_cas_no;
  end

  // complement until access time has elapsed
  always_comb begin
    if (!dram_cas_no && !dram_oe_no && dram_we_no)
      dram_dq_i = rd_ok ? mem[{row_l, dram_addr_o}] : ~mem[{row_l, dram_addr_o}];
    else
      dram_dq_i = '0;
  end

  always @(dram_ras_no, dram_cas_no, dram_we_no, dram_addr_o, dram_dq_o, dram_dq_oe_o) begin
    if (rst_ni) begin
      now = $realtime;
      if (dram_addr_o != p_addr) begin
        if (!p_ras && !cbr && (now - t_rf < TRAH)) v_r2++;
        if (!p_cas) v_r4++;
        t_ac = now;
      end
      if (!dram_we_no && p_we) t_wf = now;
      if (((dram_dq_o != p_dq) || (dram_dq_oe_o != p_dqoe)) && !dram_cas_no
          && !dram_we_no && (now - t_cf < TDH)) v_r6++;
      if (!dram_ras_no && p_ras) begin
        if (now - t_rr < TP) v_r3++;
        if (dram_cas_no) begin
          cbr = 1'b0;
          if (now - t_ac < TASR) v_r2++;
          row_l = dram_addr_o;
        end else begin
          cbr = 1'b1;
          if (now - t_cf < TCSR) v_r9++;
          ref_seen++;
        end
        ras_falls++;
        t_rf = now;
      end
      if (dram_ras_no && !p_ras) begin
        if (now - t_rf < TRAS) v_r3++;
        if (now - t_rf >= RASMAX) v_r10++;
        if (now - t_rf > max_low) max_low = now - t_rf;
        if (!cbr && (now - t_ac < TRAL)) v_r12++;
        t_rr = now;
      end
      if (!dram_cas_no && p_cas) begin
        if (now - t_cr < TCPR) v_r4++;
        if (!dram_ras_no) begin
          if (now - t_rf < TRCD) v_r4++;
          if ((t_cf > t_rf) && (now - t_cf < TPC)) v_r4++;
          if (!dram_we_no) begin
            if (now - t_wf < TWCS) v_r6++;
            if (!dram_oe_no || !dram_dq_oe_o) v_r6++;
            mem[{row_l, dram_addr_o}] = dram_dq_o;
          end
        end
        t_cf = now;
      end
      if (dram_cas_no && !p_cas) begin
        if (now - t_cf < TCAS) v_r4++;
        t_cr = now;
      end
      p_ras = dram_ras_no; p_cas = dram_cas_no; p_we = dram_we_no;
      p_addr = dram_addr_o; p_dq = dram_dq_o; p_dqoe = dram_dq_oe_o;
    end
  end

  // ---- checking ----
  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_req(input logic [7:0] addr, input logic wr, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid_i = 1'b1; req_addr_i = addr; req_write_i = wr; req_wdata_i = d;
    while (!req_ready_o) @(negedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] addr, input logic [DW-1:0] exp, input string req);
    int w;
    do_req(addr, 1'b0, '0);
    w = 0;
    while (!rsp_valid_o && w < 60) begin @(negedge clk); w++; end
    chk(rsp_valid_o && rsp_rdata_o == exp, req, {15'd0, rsp_valid_o, rsp_rdata_o}, {16'd1, exp});
  endtask

  task automatic t_reset;
    cycles(3);
    chk(dram_ras_no && dram_cas_no && dram_we_no && dram_oe_no && !dram_dq_oe_o,
        "R1 strobes in reset", {dram_ras_no, dram_cas_no, dram_we_no, dram_oe_no, dram_dq_oe_o}, 32'h1e);
    chk(!rsp_valid_o && !ref_ack_o, "R1 no pulses in reset", {rsp_valid_o, ref_ack_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!req_ready_o, "R1 ready low during precharge", req_ready_o, 0);
    cycles(6);
    chk(req_ready_o, "R1 ready after precharge", req_ready_o, 1);
  endtask

  task automatic t_single;
    do_req(8'h35, 1'b1, 16'hA5A5);
    cycles(2);
    rd_chk(8'h35, 16'hA5A5, "R5 R6 write then read");
    @(negedge clk);
    chk(!rsp_valid_o, "R5 single-cycle response", rsp_valid_o, 0);
  endtask

  task automatic t_page;
    int rf0;
    cycles(40);
    chk(dram_ras_no, "R11 row closed before page run", dram_ras_no, 1);
    rf0 = ras_falls;
    for (int c = 0; c < 3; c++) do_req({4'h7, 4'(c)}, 1'b1, 16'h7000 + 16'(c));
    for (int c = 0; c < 3; c++) rd_chk({4'h7, 4'(c)}, 16'h7000 + 16'(c), "R7 page data");
    chk(ras_falls - rf0 == 1, "R7 one row open for page run", ras_falls - rf0, 1);
  endtask

  task automatic t_miss;
    int rf0;
    rf0 = ras_falls;
    rd_chk(8'h35, 16'hA5A5, "R8 read other row");
    rd_chk(8'h72, 16'h7002, "R8 read back first row");
    chk(ras_falls - rf0 == 2, "R8 reopen on row change", ras_falls - rf0, 2);
  endtask

  task automatic t_refresh;
    int rs0, acks, w;
    do_req(8'h91, 1'b1, 16'h9191);
    cycles(6);
    rs0 = ref_seen; acks = 0; w = 0;
    @(negedge clk);
    ref_req_i = 1'b1;
    while (!ref_ack_o && w < 100) begin @(negedge clk); w++; end
    if (ref_ack_o) acks++;
    ref_req_i = 1'b0;
    @(negedge clk);
    if (ref_ack_o) acks++;
    chk(acks == 1, "R9 one-cycle acknowledge", acks, 1);
    chk(ref_seen - rs0 == 1, "R9 column-before-row refresh seen", ref_seen - rs0, 1);
    rd_chk(8'h91, 16'h9191, "R9 data kept across refresh");
  endtask

  task automatic t_idle;
    rd_chk(8'h91, 16'h9191, "R11 access before idle");
    cycles(10);
    chk(!dram_ras_no, "R11 row kept open in short gap", dram_ras_no, 0);
    cycles(30);
    chk(dram_ras_no, "R11 row closed after idle limit", dram_ras_no, 1);
  endtask

  task automatic t_rasmax;
    int rf0;
    rf0 = ras_falls;
    for (int i = 0; i < 25; i++) rd_chk({4'h5, 4'(i)}, '0, "R10 long page run data");
    chk(ras_falls - rf0 >= 2, "R10 forced close splits run", ras_falls - rf0, 2);
    chk(v_r10 == 0 && max_low < RASMAX, "R10 row low time under ceiling", int'(max_low), RASMAX);
  endtask

  task automatic t_timing;
    cycles(40);
    chk(v_r2 == 0, "R2 row address setup/hold", v_r2, 0);
    chk(v_r3 == 0, "R3 row strobe low/high times", v_r3, 0);
    chk(v_r4 == 0, "R4 column strobe timing", v_r4, 0);
    chk(v_r6 == 0, "R6 early write timing", v_r6, 0);
    chk(v_r9 == 0, "R9 refresh setup", v_r9, 0);
    chk(v_r12 == 0, "R12 column lead before row rise", v_r12, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_page();
    t_miss();
    t_refresh();
    t_idle();
    t_rasmax();
    t_timing();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule